// File: doc/BRIEF.md
# Host Register and Control Interface

This block is the processor-facing register file of a serial network controller. A host bus with active-low select, read and write strobes, a 2-bit register address and separate 8-bit input and output data buses reaches four registers: a control/status register, an interrupt mask, a data port and a baud-rate divisor. The strobes are asynchronous to the controller clock. Each one is synchronized, and only the first clock of an access counts, so a strobe held low for many cycles performs exactly one transaction.

Bytes written to the data port are paired into 16-bit words for the transmitter, which sits outside this block. A send command first flushes any odd byte that is still held, then asks the transmitter to send a frame. Sticky receive-error flags are collected from event pulses. The status flags are gated by the mask to form a single interrupt request. The divisor register guards the serial bit rate against illegal values and against changes while the controller is running.

Top module: `hostreg_ctrl`

## Requirements
- R1: A select-plus-read or select-plus-write assertion that is held low for many clock cycles counts as exactly one transaction, taken at its first synchronized cycle.
- R2: A read at address 0 returns, from bit 7 down to bit 0: frame-error flag, code-error flag, overrun flag, noise flag, transmitter idle, transmit buffer not full (the inverse of `tx_full`), receive data ready, and enable. The value is registered on the clock edge that follows read detection.
- R3: A write at address 0 sets the enable from bit 0 and requests a send when bit 1 is 1. A 1 in bit 7, 6, 5 or 4 clears, in that order, the frame-error, code-error, overrun or noise flag. A 0 in those bits, or a 1 in the other bits, leaves the other flags unchanged.
- R4: While the controller is disabled, all four error flags read 0 and error events are not recorded. Disabling the controller clears the flags.
- R5: Address 1 holds an interrupt mask whose bits 7 to 1 line up with status bits 7 to 1. Bit 0 always reads 0. `host_irq` is high when any status bit and its mask bit are both 1.
- R6: The divisor at address 3 resets to 3 and reads back. A write updates it only while the controller is disabled and only with a value from 3 to 15. All other writes leave it unchanged.
- R7: Writes to address 2 are paired. The first byte becomes bits 7:0 and the second becomes bits 15:8 of one word, which is issued with a single-cycle `tx_word_we`.
- R8: A write to address 2 while `tx_full` is 1 is dropped. It neither completes a pair nor becomes a held byte.
- R9: A send request while one byte is held first issues the word {8'h00, byte}. The `tx_frame_go` pulse follows on the next clock cycle.
- R10: A send request with no byte held and `tx_empty` at 1 is ignored. With `tx_empty` at 0, it issues only `tx_frame_go`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_sel_n | input | 1 | Host chip select, active low, asynchronous |
| host_rd_n | input | 1 | Host read strobe, active low, asynchronous |
| host_wr_n | input | 1 | Host write strobe, active low, asynchronous |
| host_addr | input | 2 | Register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| host_irq | output | 1 | Interrupt request, active high |
| tx_idle | input | 1 | Transmitter is not shifting out data |
| tx_full | input | 1 | Transmit buffer is full |
| tx_empty | input | 1 | Transmit buffer holds no word |
| rx_ready | input | 1 | Receive buffer holds data |
| ev_frame | input | 1 | Frame-error event pulse |
| ev_ecc | input | 1 | Uncorrectable code-error event pulse |
| ev_overrun | input | 1 | Receive overrun event pulse |
| ev_noise | input | 1 | Line-noise event pulse |
| tx_word_we | output | 1 | One-cycle word write toward the transmitter |
| tx_word | output | 16 | Word issued with `tx_word_we` |
| tx_frame_go | output | 1 | One-cycle send-frame command |
| baud_div | output | 8 | Current baud-rate divisor |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, two synchronizer stages, and a divisor window from 3 to 15 with a reset value of 3. With this window, a short table of divisor writes covers both edges of the range, values just past each edge, zero and all-ones. Host strobes are held for several clocks, so the first-cycle detection is exercised on every access. The narrow two-stage synchronizer keeps the latency from a strobe to a register update short enough to check the one-cycle gap between a flushed word and its frame command.

// File: rtl/hostreg_pkg.sv
package hostreg_pkg;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_MASK = 2'd1,
    REG_DATA = 2'd2,
    REG_DIV  = 2'd3
  } reg_sel_e;

  // status bit positions (decoded by host software, so fixed)
  localparam int ST_EN     = 0;
  localparam int ST_RXRDY  = 1;
  localparam int ST_TXROOM = 2;
  localparam int ST_TXIDLE = 3;
  localparam int ST_ERRLO  = 4;
  localparam int ST_ERRHI  = 7;

  // command bit positions at the control address
  localparam int CMD_EN    = 0;
  localparam int CMD_SEND  = 1;

  localparam int NERR      = 4;

  // order matches bits 7..4: frame, code, overrun, noise
  typedef struct packed {
    logic frame;
    logic code;
    logic ovr;
    logic noise;
  } err_vec_t;

  function automatic logic div_in_range(input logic [31:0] v,
                                        input logic [31:0] lo,
                                        input logic [31:0] hi);
    return (v >= lo) && (v <= hi);
  endfunction

endpackage

// File: rtl/hostreg_strobe_sync.sv
module hostreg_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n,
  input  logic rd_n,
  input  logic wr_n,
  output logic rd_go,
  output logic wr_go
);
  localparam int NSIG = 3;
  localparam int PW   = NSIG * STAGES;

  logic [PW-1:0]   pipe_q;
  logic [NSIG-1:0] synced_n;
  logic            sel_on, rd_act, wr_act, rd_act_q, wr_act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= {pipe_q[PW-NSIG-1+NSIG-NSIG:0], sel_n, rd_n, wr_n} >> 0;
  end

  assign synced_n = pipe_q[PW-1 -: NSIG];
  assign sel_on   = ~synced_n[2];
  assign rd_act   = sel_on & ~synced_n[1];
  assign wr_act   = sel_on & ~synced_n[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_act_q <= 1'b0;
      wr_act_q <= 1'b0;
    end else begin
      rd_act_q <= rd_act;
      wr_act_q <= wr_act;
    end
  end

  assign rd_go = rd_act & ~rd_act_q;
  assign wr_go = wr_act & ~wr_act_q;

  // R1
  rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> !rd_go);
  // R1
  wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> !wr_go);

endmodule

// File: rtl/hostreg_word_pack.sv
module hostreg_word_pack #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_wr,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              send_req,
  input  logic              tx_full,
  input  logic              tx_empty,
  output logic              word_we,
  output logic [2*BYTE_W-1:0] word,
  output logic              frame_go
);
  localparam int WORD_W = 2 * BYTE_W;

  function automatic logic [WORD_W-1:0] join_pair(input logic [BYTE_W-1:0] hi,
                                                  input logic [BYTE_W-1:0] lo);
    return {hi, lo};
  endfunction

  logic              held_q;
  logic [BYTE_W-1:0] hold_q;
  logic              frame_pend_q;
  logic              data_take;

  assign data_take = data_wr & ~tx_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q       <= 1'b0;
      hold_q       <= '0;
      frame_pend_q <= 1'b0;
      word_we      <= 1'b0;
      word         <= '0;
      frame_go     <= 1'b0;
    end else begin
      word_we      <= 1'b0;
      frame_go     <= frame_pend_q;
      frame_pend_q <= 1'b0;
      if (data_take) begin
        if (held_q) begin
          word    <= join_pair(byte_in, hold_q);
          word_we <= 1'b1;
          held_q  <= 1'b0;
        end else begin
          hold_q  <= byte_in;
          held_q  <= 1'b1;
        end
      end else if (send_req) begin
        if (held_q) begin
          word         <= join_pair('0, hold_q);
          word_we      <= ~tx_full;
          held_q       <= 1'b0;
          frame_pend_q <= 1'b1;
        end else if (!tx_empty) begin
          frame_go     <= 1'b1;
        end
      end
    end
  end

  // R9
  word_frame_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_we |-> !frame_go);
  // R8
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && tx_full && !send_req) |=> !word_we);
  // R10
  empty_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (send_req && !held_q && tx_empty && !frame_pend_q && !data_wr) |=> (!frame_go && !word_we));

endmodule

// File: rtl/hostreg_flags.sv
module hostreg_flags #(
  parameter int NF = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_next,
  input  logic [NF-1:0] ev,
  input  logic [NF-1:0] clr,
  output logic [NF-1:0] flags
);
  for (genvar i = 0; i < NF; i++) begin : g_flag
    logic f_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        f_q <= 1'b0;
      else if (!en_next) f_q <= 1'b0;
      else               f_q <= (f_q & ~clr[i]) | ev[i];
    end
    assign flags[i] = f_q;
  end

  // R3
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_next |=> ((flags & $past(clr & ~ev)) == '0));

endmodule

// File: rtl/hostreg_ctrl.sv
module hostreg_ctrl
  import hostreg_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_MIN     = 3,
  parameter int DIV_MAX     = 15,
  parameter int DIV_RESET   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_sel_n,
  input  logic                host_rd_n,
  input  logic                host_wr_n,
  input  logic [1:0]          host_addr,
  input  logic [BYTE_W-1:0]   host_wdata,
  output logic [BYTE_W-1:0]   host_rdata,
  output logic                host_irq,
  input  logic                tx_idle,
  input  logic                tx_full,
  input  logic                tx_empty,
  input  logic                rx_ready,
  input  logic                ev_frame,
  input  logic                ev_ecc,
  input  logic                ev_overrun,
  input  logic                ev_noise,
  output logic                tx_word_we,
  output logic [2*BYTE_W-1:0] tx_word,
  output logic                tx_frame_go,
  output logic [BYTE_W-1:0]   baud_div
);
  localparam logic [BYTE_W-1:0] MASK_KEEP = {{(BYTE_W-1){1'b1}}, 1'b0};

  logic              rd_go, wr_go;
  reg_sel_e          sel;
  logic              en_q, en_next;
  logic [BYTE_W-1:0] mask_q, div_q, status;
  err_vec_t          ev_v, clr_v, flag_v;
  logic              wr_ctrl, wr_data, send_req, div_ok;

  hostreg_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .sel_n (host_sel_n),
    .rd_n  (host_rd_n),
    .wr_n  (host_wr_n),
    .rd_go (rd_go),
    .wr_go (wr_go)
  );

  assign sel      = reg_sel_e'(host_addr);
  assign wr_ctrl  = wr_go && (sel == REG_CTRL);
  assign wr_data  = wr_go && (sel == REG_DATA);
  assign send_req = wr_ctrl && host_wdata[CMD_SEND];
  assign en_next  = wr_ctrl ? host_wdata[CMD_EN] : en_q;
  assign div_ok   = div_in_range(32'(host_wdata), 32'(DIV_MIN), 32'(DIV_MAX));

  assign ev_v  = '{frame: ev_frame, code: ev_ecc, ovr: ev_overrun, noise: ev_noise};
  assign clr_v = wr_ctrl ? err_vec_t'(host_wdata[ST_ERRHI:ST_ERRLO]) : '0;

  hostreg_flags #(.NF(NERR)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_next (en_next),
    .ev      (ev_v),
    .clr     (clr_v),
    .flags   (flag_v)
  );

  hostreg_word_pack #(.BYTE_W(BYTE_W)) u_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .data_wr  (wr_data),
    .byte_in  (host_wdata),
    .send_req (send_req),
    .tx_full  (tx_full),
    .tx_empty (tx_empty),
    .word_we  (tx_word_we),
    .word     (tx_word),
    .frame_go (tx_frame_go)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mask_q <= '0;
      div_q  <= BYTE_W'(DIV_RESET);
    end else begin
      en_q <= en_next;
      if (wr_go && sel == REG_MASK) mask_q <= host_wdata & MASK_KEEP;
      if (wr_go && sel == REG_DIV && !en_q && div_ok) div_q <= host_wdata;
    end
  end

  always_comb begin
    status                      = '0;
    status[ST_ERRHI:ST_ERRLO]   = flag_v;
    status[ST_TXIDLE]           = tx_idle;
    status[ST_TXROOM]           = ~tx_full;
    status[ST_RXRDY]            = rx_ready;
    status[ST_EN]               = en_q;
  end

  assign host_irq = |(status & mask_q);
  assign baud_div = div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) host_rdata <= '0;
    else if (rd_go) begin
      case (sel)
        REG_CTRL: host_rdata <= status;
        REG_MASK: host_rdata <= mask_q;
        REG_DIV:  host_rdata <= div_q;
        default:  host_rdata <= '0;
      endcase
    end
  end

  // R6
  div_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_q) |-> !$past(en_q));
  // R6
  div_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q >= BYTE_W'(DIV_MIN)) && (div_q <= BYTE_W'(DIV_MAX)));
  // R4
  off_flags_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (flag_v == '0));
  // R5
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !host_irq);

endmodule

// File: tb/sim_hostreg_ctrl.sv
`timescale 1ns/1ps
module sim_hostreg_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sel_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, rdata, bdiv;
  logic irq, word_we, frame_go;
  logic [15:0] word;
  logic tx_idle = 1'b1, tx_full = 1'b0, tx_empty = 1'b0, rx_ready = 1'b0;
  logic e_fr = 0, e_ec = 0, e_ov = 0, e_no = 0;

  int runs = 0, fails = 0, cyc = 0;
  int word_cnt = 0, frame_cnt = 0, word_cyc = 0, frame_cyc = 0;
  logic [15:0] last_word = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hostreg_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .host_sel_n(sel_n), .host_rd_n(rd_n), .host_wr_n(wr_n),
    .host_addr(addr), .host_wdata(wdata), .host_rdata(rdata), .host_irq(irq),
    .tx_idle(tx_idle), .tx_full(tx_full), .tx_empty(tx_empty), .rx_ready(rx_ready),
    .ev_frame(e_fr), .ev_ecc(e_ec), .ev_overrun(e_ov), .ev_noise(e_no),
    .tx_word_we(word_we), .tx_word(word), .tx_frame_go(frame_go), .baud_div(bdiv));

  always @(negedge clk) begin
    cyc++;
    if (word_we) begin word_cnt++; word_cyc = cyc; last_word = word; end
    if (frame_go) begin frame_cnt++; frame_cyc = cyc; end
  end

  // {written value, expected divisor afterwards}, all while disabled
  localparam logic [15:0] DIV_TBL [7] = '{16'h0203, 16'h0F0F, 16'h100F, 16'h0707,
                                          16'h0007, 16'h0303, 16'hFF03};

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic hwrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; sel_n = 0; wr_n = 0;
    repeat (6) @(negedge clk);
    wr_n = 1; sel_n = 1;
    repeat (6) @(negedge clk);
  endtask

  task automatic hread(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; sel_n = 0; rd_n = 0;
    repeat (6) @(negedge clk);
    d = rdata;
    rd_n = 1; sel_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: e_fr = 1; 1: e_ec = 1; 2: e_ov = 1; default: e_no = 1;
    endcase
    @(negedge clk); e_fr = 0; e_ec = 0; e_ov = 0; e_no = 0;
    @(negedge clk);
  endtask

  task automatic expect_reg(input logic [1:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] v;
    hread(a, v);
    check(v == exp, tag, v, exp);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    int wc, fc;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // reset state
    expect_reg(2'd0, 8'h0C, "R2 reset status");
    expect_reg(2'd1, 8'h00, "R5 reset mask");
    expect_reg(2'd3, 8'h03, "R6 reset divisor");
    check(irq == 0, "R5 reset irq", irq, 0);

    // divisor table, controller disabled
    foreach (DIV_TBL[i]) begin
      hwrite(2'd3, DIV_TBL[i][15:8]);
      expect_reg(2'd3, DIV_TBL[i][7:0], "R6 divisor table");
      check(bdiv == DIV_TBL[i][7:0], "R6 divisor port", bdiv, DIV_TBL[i][7:0]);
    end

    hwrite(2'd0, 8'h01);
    hwrite(2'd3, 8'h09);
    expect_reg(2'd3, 8'h03, "R6 write while enabled");

    // sticky flags
    pulse(0); pulse(3);
    expect_reg(2'd0, 8'h9D, "R2 frame+noise set");
    hwrite(2'd0, 8'h81);
    expect_reg(2'd0, 8'h1D, "R3 clear frame only");
    pulse(1); pulse(2);
    expect_reg(2'd0, 8'h7D, "R2 code+overrun set");
    hwrite(2'd0, 8'h00);
    expect_reg(2'd0, 8'h0C, "R4 disable clears");
    pulse(1);
    expect_reg(2'd0, 8'h0C, "R4 event while off");
    hwrite(2'd0, 8'h01);

    // mask and interrupt
    hwrite(2'd1, 8'hFF);
    expect_reg(2'd1, 8'hFE, "R5 mask bit0 zero");
    check(irq == 1, "R5 idle unmasked", irq, 1);
    hwrite(2'd1, 8'h02);
    check(irq == 0, "R5 ready masked in, low", irq, 0);
    rx_ready = 1; @(negedge clk);
    check(irq == 1, "R5 ready raises irq", irq, 1);
    expect_reg(2'd0, 8'h0F, "R2 ready status");
    hwrite(2'd1, 8'h00);
    check(irq == 0, "R5 mask off", irq, 0);
    rx_ready = 0;

    // byte pairing under long strobes
    hwrite(2'd2, 8'h34);
    check(word_cnt == 0, "R1 single byte no word", word_cnt, 0);
    hwrite(2'd2, 8'h12);
    check(word_cnt == 1, "R1 one word per pair", word_cnt, 1);
    check(last_word == 16'h1234, "R7 pair order", last_word, 16'h1234);
    hwrite(2'd2, 8'hCD); hwrite(2'd2, 8'hAB);
    check(last_word == 16'hABCD, "R7 second pair", last_word, 16'hABCD);

    // send with odd byte
    hwrite(2'd2, 8'hEF);
    wc = word_cnt; fc = frame_cnt;
    hwrite(2'd0, 8'h03);
    check(word_cnt == wc + 1, "R9 flush word count", word_cnt, wc + 1);
    check(last_word == 16'h00EF, "R9 flush word", last_word, 16'h00EF);
    check(frame_cnt == fc + 1, "R9 frame count", frame_cnt, fc + 1);
    check(frame_cyc == word_cyc + 1, "R9 frame one cycle later", frame_cyc, word_cyc + 1);

    // send with nothing held
    tx_empty = 1;
    wc = word_cnt; fc = frame_cnt;
    hwrite(2'd0, 8'h03);
    check(frame_cnt == fc, "R10 empty ignored", frame_cnt, fc);
    tx_empty = 0;
    hwrite(2'd0, 8'h03);
    check(frame_cnt == fc + 1, "R10 frame only", frame_cnt, fc + 1);
    check(word_cnt == wc, "R10 no word", word_cnt, wc);

    // full buffer drops data
    tx_full = 1;
    expect_reg(2'd0, 8'h09, "R2 full status");
    wc = word_cnt;
    hwrite(2'd2, 8'h55);
    check(word_cnt == wc, "R8 dropped no word", word_cnt, wc);
    tx_full = 0;
    hwrite(2'd2, 8'h66); hwrite(2'd2, 8'h77);
    check(last_word == 16'h7766, "R8 dropped byte not held", last_word, 16'h7766);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule